// File: doc/BRIEF.md
# Round-Robin Interrupt Concentrator and Dispatcher

This block gathers a set of discrete level interrupt lines and turns them into packets. A scanner visits one line per clock in a fixed rotation. For each visit it emits a 6-bit code: the line's index when the line is asserted, or the reserved value 63 when it is not. Most lines are active-low. The four highest-numbered lines are active-high.

A dispatcher watches this code stream. It ignores codes for sources that the ownership mask does not mark. Each owned source has a small state machine with three states: idle, received and pending. A source that is seen while idle becomes received. Received sources are offered one at a time, lowest index first, as packets on a valid/ready port. The packet carries an 11-bit interrupt number, built as the 5-bit group number on top of the 6-bit source code.

Once its packet is accepted, the source waits in the pending state. It emits nothing more until software writes its index to the clear strobe.

Top module: `irq_concentrator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `scan_vec` reads 63 and `pkt_valid` is 0. Every tracker is idle.
- R2: The scanner visits source 0, 1, … N_SRC-1 and then wraps to 0, one source per clock. The line sampled at an edge appears on `scan_vec` after that edge. An asserted source reports its own index as the code.
- R3: When the visited line is inactive, the code is 63.
- R4: Lines N_SRC-4 to N_SRC-1 are asserted when high. All other lines are asserted when low.
- R5: Codes for sources whose `own_mask` bit is 0 never produce a packet.
- R6: An owned source whose code appears while its tracker is idle becomes received. It is then offered as a packet with `pkt_inr` = {`ign`[4:0], index[5:0]}. The group number is taken when the packet is loaded.
- R7: After a source's packet is accepted (`pkt_valid` and `pkt_ready` high at an edge), that source is pending. Further codes for it produce no packets.
- R8: A clock with `clr_we` high and `clr_idx` equal to a source's index returns that source to idle, whatever its state. A `clr_idx` of N_SRC or above has no effect.
- R9: When more than one source is received and not already on the output, the lowest index is loaded next.
- R10: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `pkt_inr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Level interrupt lines, with mixed polarity |
| own_mask | input | N_SRC | Sources that this dispatcher owns |
| ign | input | 5 | Interrupt group number placed in the packet |
| clr_we | input | 1 | Clear strobe |
| clr_idx | input | 6 | Index of the source to clear |
| scan_vec | output | 6 | Sampled code, or 63 for an inactive line |
| pkt_valid | output | 1 | A packet is offered |
| pkt_inr | output | 11 | Interrupt number of the offered packet |
| pkt_ready | input | 1 | Consumer accepts the packet |

## Verification
Results appear at fixed delays:
- A line sampled at an edge shows on `scan_vec` right after that edge.
- The tracker becomes received at the following edge.
- The packet is loaded one edge after that, if the output register is free. The whole path from sampled line to `pkt_valid` takes three clock edges.

Inputs change 2 ns after a rising edge. A bench model advances at the same edge, and outputs are compared with it at every falling edge, so every check lands in the cycle the result is due. Directed phases cover the following, using counts gathered over whole rotations so that the scan position does not matter:
- polarity
- ownership
- ascending order
- the pending block
- clear
- output hold under back-pressure

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int VEC_W = 6;
  localparam int IGN_W = 5;
  localparam int INR_W = IGN_W + VEC_W;
  localparam logic [VEC_W-1:0] IDLE_CODE = '1;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_RCVD = 2'd1,
    TRK_PEND = 2'd2
  } trk_state_e;
endpackage

// File: rtl/irqc_scanner.sv
module irqc_scanner
  import irqc_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter logic [N_SRC-1:0] ACT_HIGH = {4'hF, {(N_SRC-4){1'b0}}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_SRC-1:0]     irq_in,
  output logic [VEC_W-1:0]     scan_vec
);
  localparam int PTR_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_SRC - 1);

  logic [PTR_W-1:0] ptr;
  logic             line_on;

  assign line_on = ACT_HIGH[ptr] ? irq_in[ptr] : ~irq_in[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      scan_vec <= IDLE_CODE;
    end else begin
      scan_vec <= line_on ? VEC_W'(ptr) : IDLE_CODE;
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_vec == IDLE_CODE) || (scan_vec < VEC_W'(N_SRC)));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/irqc_tracker.sv
module irqc_tracker
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic accept,
  output logic rcvd
);
  trk_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TRK_IDLE;
    end else if (clr) begin
      st <= TRK_IDLE;
    end else begin
      unique case (st)
        TRK_IDLE: if (hit)    st <= TRK_RCVD;
        TRK_RCVD: if (accept) st <= TRK_PEND;
        default:              st <= st;
      endcase
    end
  end

  assign rcvd = (st == TRK_RCVD);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TRK_PEND && !clr) |=> (st == TRK_PEND));

  // R6
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TRK_IDLE && !hit) |=> (st == TRK_IDLE));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st == TRK_IDLE));
endmodule

// File: rtl/irqc_dispatch.sv
module irqc_dispatch
  import irqc_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   rcvd,
  input  logic [IGN_W-1:0]   ign,
  input  logic               pkt_ready,
  output logic [N_SRC-1:0]   accept,
  output logic               pkt_valid,
  output logic [INR_W-1:0]   pkt_inr
);
  logic [VEC_W-1:0] held;
  logic [VEC_W-1:0] sel;
  logic             found;
  logic [N_SRC-1:0] cand;
  logic             take;

  assign take = pkt_valid && pkt_ready;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      cand[i]   = rcvd[i] && !(pkt_valid && held == VEC_W'(i));
      accept[i] = take && (held == VEC_W'(i));
    end
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        sel   = VEC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      held      <= '0;
      pkt_inr   <= '0;
    end else if (!pkt_valid || take) begin
      if (found) begin
        pkt_valid <= 1'b1;
        held      <= sel;
        pkt_inr   <= {ign, sel};
      end else begin
        pkt_valid <= 1'b0;
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_inr)));

  // R6
  inr_src_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_inr[VEC_W-1:0] < VEC_W'(N_SRC)));

  // R7
  one_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(accept));
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter logic [N_SRC-1:0] ACT_HIGH = {4'hF, {(N_SRC-4){1'b0}}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_SRC-1:0]     irq_in,
  input  logic [N_SRC-1:0]     own_mask,
  input  logic [IGN_W-1:0]     ign,
  input  logic                 clr_we,
  input  logic [VEC_W-1:0]     clr_idx,
  output logic [VEC_W-1:0]     scan_vec,
  output logic                 pkt_valid,
  output logic [INR_W-1:0]     pkt_inr,
  input  logic                 pkt_ready
);
  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] rcvd;
  logic [N_SRC-1:0] accept;

  irqc_scanner #(.N_SRC(N_SRC), .ACT_HIGH(ACT_HIGH)) u_scan (
    .clk(clk), .rst(rst), .irq_in(irq_in), .scan_vec(scan_vec)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_trk
    assign hit[g] = own_mask[g] && (scan_vec == VEC_W'(g));
    assign clr[g] = clr_we && (clr_idx == VEC_W'(g));
    irqc_tracker u_trk (
      .clk(clk), .rst(rst), .hit(hit[g]), .clr(clr[g]),
      .accept(accept[g]), .rcvd(rcvd[g])
    );
  end

  irqc_dispatch #(.N_SRC(N_SRC)) u_disp (
    .clk(clk), .rst(rst), .rcvd(rcvd), .ign(ign), .pkt_ready(pkt_ready),
    .accept(accept), .pkt_valid(pkt_valid), .pkt_inr(pkt_inr)
  );

  // R5
  unowned_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready && $rose(pkt_valid)) |-> (rcvd != '0));
endmodule

// File: tb/irq_concentrator_bench.sv
`timescale 1ns/1ps
module irq_concentrator_bench;
  localparam int N = 16;
  localparam logic [N-1:0] HI = 16'hF000;
  localparam logic [N-1:0] ALL_OFF = 16'h0FFF;
  localparam logic [N-1:0] ALL_ON  = 16'hF000;

  logic clk = 0, rst = 1;
  logic [N-1:0] irq_in = ALL_OFF, own_mask = '0;
  logic [4:0] ign = '0;
  logic clr_we = 0;
  logic [5:0] clr_idx = '0;
  logic [5:0] scan_vec;
  logic pkt_valid, pkt_ready = 0;
  logic [10:0] pkt_inr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_concentrator u_irq_concentrator (
    .clk(clk), .rst(rst), .irq_in(irq_in), .own_mask(own_mask), .ign(ign),
    .clr_we(clr_we), .clr_idx(clr_idx), .scan_vec(scan_vec),
    .pkt_valid(pkt_valid), .pkt_inr(pkt_inr), .pkt_ready(pkt_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit line_on(input int i, input logic [N-1:0] v);
    return HI[i] ? v[i] : ~v[i];
  endfunction

  // reference model built from the requirements
  int m_ptr, m_vec, m_st[N], m_idx;
  bit m_pv;
  int m_inr;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_vec = 63; m_pv = 0; m_idx = 0; m_inr = 0;
      for (int i = 0; i < N; i++) m_st[i] = 0;
    end else begin
      bit acc, fnd;
      int s, nst[N];
      acc = m_pv && pkt_ready;
      fnd = 0; s = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_st[i] == 1 && !(m_pv && m_idx == i)) begin fnd = 1; s = i; end
      for (int i = 0; i < N; i++) begin
        nst[i] = m_st[i];
        if (clr_we && clr_idx == i) nst[i] = 0;
        else if (m_st[i] == 0 && own_mask[i] && m_vec == i) nst[i] = 1;
        else if (m_st[i] == 1 && acc && m_idx == i) nst[i] = 2;
      end
      for (int i = 0; i < N; i++) m_st[i] = nst[i];
      if (!m_pv || acc) begin
        if (fnd) begin m_pv = 1; m_idx = s; m_inr = {ign, 6'(s)}; end
        else m_pv = 0;
      end
      m_vec = line_on(m_ptr, irq_in) ? m_ptr : 63;
      m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    end
  end

  int acc_q[$];
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(scan_vec == 6'(m_vec), (m_vec == 63) ? "R3 scan code" : "R2 scan code", scan_vec, m_vec);
      chk(pkt_valid == m_pv, "R6 pkt_valid", pkt_valid, m_pv);
      if (m_pv) chk(pkt_inr == 11'(m_inr), "R6 pkt_inr", pkt_inr, m_inr);
      if (pkt_valid && pkt_ready) acc_q.push_back(int'(pkt_inr));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int seed, cnt, prev;
    logic [N-1:0] seen;
    logic [10:0] hold_v;
    seed = 1234;
    void'($urandom(seed));
    step(4);
    @(negedge clk);
    // R1 reset state
    chk(scan_vec == 6'd63, "R1 reset scan_vec", scan_vec, 63);
    chk(pkt_valid == 0, "R1 reset pkt_valid", pkt_valid, 0);
    step(1); rst = 0;
    @(negedge clk);
    chk(scan_vec == 6'd63 && !pkt_valid, "R1 first cycle", scan_vec, 63);

    // R3: all lines inactive gives only idle codes
    cnt = 0;
    for (int k = 0; k < 2 * N; k++) begin @(negedge clk); if (scan_vec != 6'd63) cnt++; end
    chk(cnt == 0, "R3 idle only", cnt, 0);

    // R4: all lines high, only the top four are asserted
    step(1); irq_in = '1; seen = '0;
    step(2);
    for (int k = 0; k < 2 * N; k++) begin
      @(negedge clk); if (scan_vec != 6'd63) seen[scan_vec[3:0]] = 1'b1;
    end
    chk(seen == 16'hF000, "R4 polarity", seen, 16'hF000);

    // R5: nothing owned, everything asserted
    step(1); irq_in = ALL_ON; pkt_ready = 1; cnt = 0;
    for (int k = 0; k < 3 * N; k++) begin @(negedge clk); if (pkt_valid) cnt++; end
    chk(cnt == 0, "R5 unowned", cnt, 0);

    // R9/R6: all owned, back-pressure, then ascending release
    step(1); ign = 5'h15; pkt_ready = 0; own_mask = '1;
    step(3 * N);
    acc_q.delete(); pkt_ready = 1;
    step(N + 6);
    chk(acc_q.size() == N, "R9 packet count", acc_q.size(), N);
    prev = -1;
    for (int k = 1; k < acc_q.size(); k++) begin
      chk((acc_q[k] & 63) > prev, "R9 ascending", acc_q[k] & 63, prev + 1);
      prev = acc_q[k] & 63;
    end
    if (acc_q.size() > 0) chk((acc_q[0] >> 6) == 5'h15, "R6 group field", acc_q[0] >> 6, 5'h15);

    // R7: pending sources stay quiet
    acc_q.delete(); step(3 * N);
    chk(acc_q.size() == 0, "R7 no repeat", acc_q.size(), 0);

    // R8: clear one source, it fires once more
    clr_we = 1; clr_idx = 6'd5; step(1); clr_we = 0;
    step(2 * N);
    chk(acc_q.size() == 1, "R8 clear count", acc_q.size(), 1);
    if (acc_q.size() > 0) chk((acc_q[0] & 63) == 5, "R8 cleared source", acc_q[0] & 63, 5);

    // R8: out-of-range clear has no effect
    acc_q.delete(); clr_we = 1; clr_idx = 6'd40; step(1); clr_we = 0;
    step(2 * N);
    chk(acc_q.size() == 0, "R8 range clear", acc_q.size(), 0);

    // R10: hold under back-pressure
    pkt_ready = 0; clr_we = 1; clr_idx = 6'd3; step(1); clr_we = 0;
    step(2 * N);
    @(negedge clk);
    chk(pkt_valid && pkt_inr == {5'h15, 6'd3}, "R10 offered", pkt_inr, {5'h15, 6'd3});
    hold_v = pkt_inr;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(pkt_valid && pkt_inr == hold_v, "R10 stable", pkt_inr, hold_v);
    end
    step(1); pkt_ready = 1; step(4);

    // random phase, checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 8 == 0) irq_in = N'($urandom);
      pkt_ready = ($urandom % 4) != 0;
      clr_we = ($urandom % 10) == 0;
      clr_idx = ($urandom % 5 == 0) ? 6'($urandom) : 6'($urandom % N);
      if ($urandom % 200 == 0) own_mask = N'($urandom);
      if ($urandom % 300 == 0) ign = 5'($urandom);
      step(1);
    end
    clr_we = 0;
    step(4);
    finish_run();
  end
endmodule